// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block keeps the protection state of a serial flash status register and rules on every decoded command before the program and erase engine acts on it. A command decoder presents one command per cycle as a strobe plus a 3-bit code, with the data byte that goes with a status write and the target byte address of a program or erase. One cycle later, the controller answers with a single-cycle grant or a single-cycle reject pulse. When the command is granted, its effect on the protection bits appears in that same cycle.

Four things shape each decision: a write enable latch, a set of block-protect bits that cover a region at the top of the array, and a hardware-protected mode formed by a register bit and the active-low write-protect pin. A mode bit can cut that pin out of the decision. In OTP mode, the protect bit is shown as a one-time lock for the OTP sector instead. A status write in that mode sets the lock whatever data it carries. The block also exposes the status byte and a captured suspend status byte. The non-volatile bits are plain registers that clear on reset.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset, status bits 7..1 are 0, grant and reject are low and the suspend status byte is 0. The status byte is laid out as follows: bit 0 is the wip input, bit 1 is the write enable latch, bits 5..2 are the block-protect value BP, bit 6 is the pin-disable bit and bit 7 is the protect bit (the OTP lock in OTP mode).
- R2: Outside OTP mode, a status write (code 2) is rejected while the protect bit is 1, wp_n is 0 and the pin-disable bit is 0.
- R3: Outside OTP mode, a status write with the latch set and no hardware protection is granted. It loads status bits 7..2 from the same bit positions of wr_data and clears the latch.
- R4: Outside OTP mode, a chip erase (code 6) is granted only when BP is 0.
- R5: While the pin-disable bit is 1, wp_n has no effect on any decision.
- R6: Outside OTP mode, page program (code 3), sector erase (code 4) and block erase (code 5) are rejected when the address falls in the protected region. The block index is the top 6 address bits. When BP is not 0, the protected region is the top min(64, 2^(BP-1)) of the 64 blocks. When BP is 0, nothing is protected.
- R7: In OTP mode, a status write ignores wr_data and sets the OTP lock, which status bit 7 then shows. Once the lock is 1, a further status write is rejected and the lock never returns to 0 except by reset.
- R8: In OTP mode, program and erase commands (codes 3..6) are granted with the latch set and the lock at 0, and they are rejected once the lock is 1.
- R9: A read-suspend-status command (code 7) is always granted, whatever wip and the protection state are. It copies susp_in into susp_status.
- R10: Write-enable (code 0) sets the latch and write-disable (code 1) clears it; both are always granted. Codes 2..6 are rejected while the latch is 0. Each granted code 2..6 clears the latch.
- R11: The grant or reject pulse appears in the cycle after the strobe and lasts one cycle. A rejected command leaves every status bit unchanged. Status bit 0 follows wip regardless of any decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command code (0..7, see requirements) |
| wr_data | input | 8 | Data byte of a status write |
| addr | input | ADDR_W | Target byte address of program or erase |
| wp_n | input | 1 | Write-protect pin, active low |
| otp_mode | input | 1 | OTP mode active |
| wip | input | 1 | Write-in-progress flag from the program/erase engine |
| susp_in | input | 8 | Live suspend status from the engine |
| grant | output | 1 | Command accepted (one-cycle pulse) |
| reject | output | 1 | Command denied (one-cycle pulse) |
| status | output | 8 | Status byte |
| susp_status | output | 8 | Suspend status captured by the last read-suspend-status |

## Verification
The bench aims at the edges of the protected region: block 61 against block 62 at BP=2, a BP of 7 or 15 that must cover the whole array, and BP=1 that covers only the last block. A design with an off-by-one region or an unclamped shift would grant a write into protected memory, or deny one into free memory. The bench pairs a low wp_n with the pin-disable bit both clear and set, because a design that ignored the disable bit would lock out status writes for good. It also tries a second status write in OTP mode after the lock is set, and checks that status bit 7 switches source with otp_mode. A design that re-armed the lock, or wrote the data byte into the lock, would show the wrong bit 7 or let the OTP sector be erased.

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl #(
  parameter int ADDR_W = 22,
  parameter int BLK_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wp_n,
  input  logic              otp_mode,
  input  logic              wip,
  input  logic [7:0]        susp_in,
  output logic              grant,
  output logic              reject,
  output logic [7:0]        status,
  output logic [7:0]        susp_status
);

  localparam logic [2:0] OP_WREN  = 3'd0;
  localparam logic [2:0] OP_WRDI  = 3'd1;
  localparam logic [2:0] OP_WRSR  = 3'd2;
  localparam logic [2:0] OP_PP    = 3'd3;
  localparam logic [2:0] OP_SE    = 3'd4;
  localparam logic [2:0] OP_BE    = 3'd5;
  localparam logic [2:0] OP_CE    = 3'd6;
  localparam logic [2:0] OP_RDSSR = 3'd7;
  localparam int         NBLK     = 1 << BLK_W;
  localparam logic [BLK_W:0] NBLK_V = (BLK_W+1)'(NBLK);
  localparam logic [3:0] BP_ALL   = 4'(BLK_W + 1);

  logic       srp, wpdis, wel, otp_lock;
  logic [3:0] bp;
  logic       ok;

  wire [BLK_W-1:0] blk      = addr[ADDR_W-1 -: BLK_W];
  wire [BLK_W:0]   prot_cnt = (bp >= BP_ALL) ? NBLK_V
                                             : ((BLK_W+1)'(1) << (bp - 4'd1));
  wire             in_prot  = (bp != 4'd0) && ({1'b0, blk} >= (NBLK_V - prot_cnt));
  wire             hpm      = srp & ~wp_n & ~wpdis;
  wire             otp_open = ~otp_lock;

  always_comb begin
    case (cmd_op)
      OP_WRSR:             ok = wel & (otp_mode ? otp_open : ~hpm);
      OP_PP, OP_SE, OP_BE: ok = wel & (otp_mode ? otp_open : ~in_prot);
      OP_CE:               ok = wel & (otp_mode ? otp_open : (bp == 4'd0));
      default:             ok = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant       <= 1'b0;
      reject      <= 1'b0;
      srp         <= 1'b0;
      wpdis       <= 1'b0;
      bp          <= 4'd0;
      wel         <= 1'b0;
      otp_lock    <= 1'b0;
      susp_status <= 8'd0;
    end else begin
      grant  <= cmd_valid & ok;
      reject <= cmd_valid & ~ok;
      if (cmd_valid && ok) begin
        case (cmd_op)
          OP_WREN:  wel <= 1'b1;
          OP_WRDI:  wel <= 1'b0;
          OP_WRSR: begin
            wel <= 1'b0;
            if (otp_mode) otp_lock <= 1'b1;
            else {srp, wpdis, bp} <= wr_data[7:2];
          end
          OP_RDSSR: susp_status <= susp_in;
          default:  wel <= 1'b0;
        endcase
      end
    end
  end

  assign status = {otp_mode ? otp_lock : srp, wpdis, bp, wel, wip};

  assert_hpm_blocks_wrsr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_WRSR && !otp_mode && status[7] && !wp_n && !status[6])
      |=> reject);

  assert_ce_needs_bp_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_CE && !otp_mode && status[5:2] != 4'd0) |=> reject);

  assert_otp_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    otp_lock |=> otp_lock);

  assert_rdssr_always_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_RDSSR) |=> (grant && susp_status == $past(susp_in)));

  assert_wel_required_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op >= OP_WRSR && cmd_op <= OP_CE && !status[1]) |=> reject);

  assert_reject_keeps_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> $stable({srp, wpdis, bp, wel, otp_lock}));

  assert_pulse_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && reject));

endmodule

// File: tb/tb_flash_wp_ctrl.sv
`timescale 1ns/1ps
module tb_flash_wp_ctrl;
  localparam int ADDR_W = 22;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] wr_data = 8'd0, susp_in = 8'd0;
  logic [ADDR_W-1:0] addr = '0;
  logic wp_n = 1'b1, otp_mode = 1'b0, wip = 1'b0;
  logic grant, reject;
  logic [7:0] status, susp_status;

  int checks = 0, failures = 0;
  bit done = 0;
  string cur_req = "R1";

  flash_wp_ctrl #(.ADDR_W(ADDR_W), .BLK_W(6)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .wr_data(wr_data), .addr(addr), .wp_n(wp_n), .otp_mode(otp_mode),
    .wip(wip), .susp_in(susp_in), .grant(grant), .reject(reject),
    .status(status), .susp_status(susp_status));

  always #2.5 clk = ~clk;

  // behavioural reference
  bit m_srp, m_wpdis, m_wel, m_lock, m_g, m_r;
  int m_bp;
  bit [7:0] m_susp;

  function automatic bit allowed(int op);
    int blk, n;
    bit hw;
    blk = int'(addr >> (ADDR_W - 6));
    n = (m_bp >= 7) ? 64 : (m_bp == 0 ? 0 : (1 << (m_bp - 1)));
    hw = m_srp && !wp_n && !m_wpdis;
    if (op < 2 || op == 7) return 1;
    if (!m_wel) return 0;
    if (otp_mode) return !m_lock;
    if (op == 2) return !hw;
    if (op == 6) return m_bp == 0;
    return !(blk >= 64 - n);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_srp = 0; m_wpdis = 0; m_wel = 0; m_lock = 0; m_bp = 0;
      m_susp = 0; m_g = 0; m_r = 0;
    end else begin
      m_g = 0; m_r = 0;
      if (cmd_valid) begin
        if (allowed(int'(cmd_op))) begin
          m_g = 1;
          if (cmd_op == 0) m_wel = 1;
          else if (cmd_op == 7) m_susp = susp_in;
          else begin
            m_wel = 0;
            if (cmd_op == 2) begin
              if (otp_mode) m_lock = 1;
              else begin
                m_srp = wr_data[7]; m_wpdis = wr_data[6]; m_bp = int'(wr_data[5:2]);
              end
            end
          end
        end else m_r = 1;
      end
    end
  end

  function automatic bit [7:0] exp_status();
    return {otp_mode ? m_lock : m_srp, m_wpdis, 4'(m_bp), m_wel, wip};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk({cur_req, " grant"}, {7'd0, grant}, {7'd0, m_g});
    chk({cur_req, " reject"}, {7'd0, reject}, {7'd0, m_r});
    chk({cur_req, " status"}, status, exp_status());
    chk({cur_req, " susp"}, susp_status, m_susp);
  end

  task automatic cmd(input logic [2:0] op, input logic [7:0] d, input int blk);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; wr_data = d;
    addr = ADDR_W'(blk) << (ADDR_W - 6);
    addr[3:0] = 4'h5;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    chk("R1 reset status", status, 8'h00);
    chk("R1 reset pulses", {6'd0, grant, reject}, 8'h00);

    cur_req = "R10";
    cmd(3'd2, 8'h88, 0); chk("R10 wrsr no wel", {7'd0, reject}, 8'h01);
    cmd(3'd0, 0, 0);     chk("R10 wren", status, 8'h02);
    cmd(3'd1, 0, 0);     chk("R10 wrdi", status, 8'h00);
    cmd(3'd3, 0, 0);     chk("R10 pp no wel", {7'd0, reject}, 8'h01);

    cur_req = "R3";
    cmd(3'd0, 0, 0); cmd(3'd2, 8'h8B, 0);
    chk("R3 wrsr loads", status, 8'h88);

    cur_req = "R6";
    cmd(3'd0, 0, 0);
    cmd(3'd3, 0, 63); chk("R6 blk63", {7'd0, reject}, 8'h01);
    cmd(3'd4, 0, 62); chk("R6 blk62", {7'd0, reject}, 8'h01);
    cmd(3'd5, 0, 61); chk("R6 blk61", {7'd0, grant}, 8'h01);

    cur_req = "R4";
    cmd(3'd0, 0, 0); cmd(3'd6, 0, 0);
    chk("R4 ce bp2", {7'd0, reject}, 8'h01);

    cur_req = "R2";
    wp_n = 0;
    cmd(3'd2, 8'h00, 0);
    chk("R2 hpm wrsr", {7'd0, reject}, 8'h01);
    chk("R11 reject keeps", status, 8'h8A);

    cur_req = "R5";
    wp_n = 1;
    cmd(3'd2, 8'hC0, 0);
    wp_n = 0;
    cmd(3'd0, 0, 0); cmd(3'd2, 8'hC4, 0);
    chk("R5 pin ignored", status, 8'hC4);

    cur_req = "R6";
    cmd(3'd0, 0, 0);
    cmd(3'd3, 0, 63); cmd(3'd3, 0, 62);
    chk("R6 bp1 blk62", {7'd0, grant}, 8'h01);

    cur_req = "R4";
    cmd(3'd0, 0, 0); cmd(3'd2, 8'h40, 0);
    cmd(3'd0, 0, 0); cmd(3'd6, 0, 0);
    chk("R4 ce bp0", {7'd0, grant}, 8'h01);

    cur_req = "R6";
    cmd(3'd0, 0, 0); cmd(3'd2, 8'h1C, 0);
    cmd(3'd0, 0, 0); cmd(3'd3, 0, 0);
    chk("R6 bp7 blk0", {7'd0, reject}, 8'h01);
    cmd(3'd2, 8'h3C, 0);
    cmd(3'd0, 0, 0); cmd(3'd4, 0, 0); cmd(3'd5, 0, 31);
    cmd(3'd2, 8'h14, 0);
    cmd(3'd0, 0, 0); cmd(3'd3, 0, 47); cmd(3'd0, 0, 0); cmd(3'd3, 0, 48);
    cmd(3'd2, 8'h00, 0);

    cur_req = "R9";
    wip = 1; susp_in = 8'hA5;
    cmd(3'd7, 0, 0);
    chk("R9 rdssr", susp_status, 8'hA5);
    susp_in = 8'h3C;
    cmd(3'd7, 0, 0);
    wip = 0;

    cur_req = "R8";
    otp_mode = 1; wp_n = 1;
    cmd(3'd0, 0, 0); cmd(3'd3, 0, 63);
    chk("R8 otp pp open", {7'd0, grant}, 8'h01);

    cur_req = "R7";
    cmd(3'd0, 0, 0); cmd(3'd2, 8'h00, 0);
    chk("R7 lock set", status[7], 1'b1);
    cmd(3'd0, 0, 0); cmd(3'd2, 8'h00, 0);
    chk("R7 second wrsr", {7'd0, reject}, 8'h01);

    cur_req = "R8";
    cmd(3'd3, 0, 0); cmd(3'd4, 0, 0); cmd(3'd6, 0, 0);
    chk("R8 otp ce locked", {7'd0, reject}, 8'h01);
    otp_mode = 0;
    @(negedge clk);
    chk("R7 bit7 source", status[7], 1'b0);

    cur_req = "R11";
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule